// File: doc/BRIEF.md
# Transmit DMA Channel with Chained, One-Shot and Periodic Completion

This block is one transmit DMA channel. It reads bytes from external memory one at a time and hands them to a UART transmitter over a ready/valid byte stream. A processor programs it through a small register port. That port sets the operating mode, the starting pointer, the bounds of a circular buffer, a byte count and the interrupt mask. A command register starts the channel and asks it to stop.

Each mode ends a transfer in its own way:

- **Header chaining.** The channel reads a two-byte length header from memory. It sends that many bytes and then reads the next header, which sits directly after the data. A zero length ends the chain.
- **One-shot.** The channel sends the programmed count and then halts.
- **Free-running.** The channel keeps sending until told to stop. It raises the interrupt each time its down-counter runs out, and at that point the counter reloads from the count register.

The pointer either wraps inside a circular window or simply counts upward.

Top module: `txdma_chan`

## Requirements
- R1: After reset, `tx_valid`, `mem_req` and `irq` are low. The status register (index 6) reads 0, with bit 0 as the interrupt flag and bit 1 as busy.
- R2: In one-shot mode (control bits [1:0] = 1), a go command (write bit 0 of index 5) sends COUNT bytes (index 4), read in order starting at START (index 1). It then sets the interrupt flag and returns to idle.
- R3: A go command is ignored when the count is zero in one-shot or free-running mode, and when the mode code is 3. Nothing is sent and the flag is not touched.
- R4: In chaining mode (mode code 0), the channel first reads a header at START: a 16-bit length, low byte first. For a non-zero length it sends that many bytes from the addresses that follow the header. It then reads the next header from the address after the last data byte.
- R5: In chaining mode, a header length of zero sets the interrupt flag and returns the channel to idle.
- R6: In free-running mode (mode code 2), the channel sends bytes continuously. Each time its counter reaches zero, the counter reloads from COUNT and the flag is set.
- R7: A stop command (write bit 1 of index 5) takes effect when the byte in flight is accepted. The channel then goes idle, and the pointer (read at index 7) holds the address after the last accepted byte.
- R8: With control bit 2 set (circular), the address after HI (index 3) is LO (index 2).
- R9: With control bit 2 clear (linear), the address increments past HI without wrapping.
- R10: `irq` equals the flag ANDed with control bit 3 (mask enable). Writing 1 to bit 0 of index 6 clears the flag. A flag-setting event in the same cycle wins over the clear.
- R11: While `tx_valid` is high and `tx_ready` is low, `mem_req` stays low and `tx_data` holds its value.
- R12: `mem_req` is a one-cycle pulse. No new request is issued before the response (`mem_rvalid`) to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index for writes and reads |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for `cfg_addr` |
| mem_req | output | 1 | Single-cycle memory read request |
| mem_addr | output | AW | Byte address of the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 8 | Read response byte |
| tx_valid | output | 1 | Byte available to the UART |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART accepts the byte |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the channel with its default parameters: 16-bit addresses, counts and register data, and the wrap logic generated in. Because the circular window is set through registers, a window only a few bytes wide makes the wrap occur within a handful of transfers. The full 16-bit count lets a header whose bytes were read in the wrong order show up as a wildly wrong length. The memory model answers every request one cycle after it is issued, and the UART ready line is held high, toggled or held low. This exposes both stalled output and pipelined request timing.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

   typedef enum logic [1:0] {
      MODE_CHAIN    = 2'd0,
      MODE_ONESHOT  = 2'd1,
      MODE_FREERUN  = 2'd2,
      MODE_RSVD     = 2'd3
   } txdma_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HLO_REQ,
      ST_HLO_WAIT,
      ST_HHI_REQ,
      ST_HHI_WAIT,
      ST_DAT_REQ,
      ST_DAT_WAIT,
      ST_DAT_OUT
   } txdma_state_e;

   localparam logic [2:0] IDX_CTRL   = 3'd0;
   localparam logic [2:0] IDX_START  = 3'd1;
   localparam logic [2:0] IDX_LO     = 3'd2;
   localparam logic [2:0] IDX_HI     = 3'd3;
   localparam logic [2:0] IDX_COUNT  = 3'd4;
   localparam logic [2:0] IDX_CMD    = 3'd5;
   localparam logic [2:0] IDX_STATUS = 3'd6;
   localparam logic [2:0] IDX_PTR    = 3'd7;

   localparam int HDR_BITS = 16;

endpackage

// File: rtl/txdma_addr.sv
module txdma_addr #(
   parameter int AW      = 16,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic          circ,
   output logic [AW-1:0] nxt
);

   localparam logic [AW-1:0] ONE = AW'(1);

   generate
      if (WRAP_EN) begin : g_wrap
         assign nxt = (circ && (cur == hi)) ? lo : cur + ONE;
      end else begin : g_linear
         logic unused_bounds;
         assign unused_bounds = ^{lo, hi, circ};
         assign nxt = cur + ONE;
      end
   endgenerate

endmodule

// File: rtl/txdma_regs.sv
module txdma_regs
   import txdma_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   input  logic          busy,
   input  logic [AW-1:0] ptr,
   input  logic          irq_set,
   output txdma_mode_e   mode,
   output logic          circ,
   output logic          mask,
   output logic [AW-1:0] start,
   output logic [AW-1:0] lo,
   output logic [AW-1:0] hi,
   output logic [CW-1:0] count,
   output logic          go,
   output logic          stop,
   output logic          status,
   output logic          irq
);

   logic wr_ctrl, wr_start, wr_lo, wr_hi, wr_count, wr_cmd, wr_status;

   always_comb begin
      wr_ctrl   = cfg_we && (cfg_addr == IDX_CTRL);
      wr_start  = cfg_we && (cfg_addr == IDX_START);
      wr_lo     = cfg_we && (cfg_addr == IDX_LO);
      wr_hi     = cfg_we && (cfg_addr == IDX_HI);
      wr_count  = cfg_we && (cfg_addr == IDX_COUNT);
      wr_cmd    = cfg_we && (cfg_addr == IDX_CMD);
      wr_status = cfg_we && (cfg_addr == IDX_STATUS);
   end

   assign go   = wr_cmd && cfg_wdata[0];
   assign stop = wr_cmd && cfg_wdata[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= MODE_CHAIN;
         circ   <= 1'b0;
         mask   <= 1'b0;
         start  <= '0;
         lo     <= '0;
         hi     <= '0;
         count  <= '0;
         status <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            mode <= txdma_mode_e'(cfg_wdata[1:0]);
            circ <= cfg_wdata[2];
            mask <= cfg_wdata[3];
         end
         if (wr_start) start <= cfg_wdata[AW-1:0];
         if (wr_lo)    lo    <= cfg_wdata[AW-1:0];
         if (wr_hi)    hi    <= cfg_wdata[AW-1:0];
         if (wr_count) count <= cfg_wdata[CW-1:0];
         if (irq_set)
            status <= 1'b1;
         else if (wr_status && cfg_wdata[0])
            status <= 1'b0;
      end
   end

   assign irq = status & mask;

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         IDX_CTRL:   cfg_rdata = DW'({mask, circ, mode});
         IDX_START:  cfg_rdata = DW'(start);
         IDX_LO:     cfg_rdata = DW'(lo);
         IDX_HI:     cfg_rdata = DW'(hi);
         IDX_COUNT:  cfg_rdata = DW'(count);
         IDX_STATUS: cfg_rdata = DW'({busy, status});
         IDX_PTR:    cfg_rdata = DW'(ptr);
         default:    cfg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
   import txdma_pkg::*;
#(
   parameter int AW      = 16,
   parameter int CW      = 16,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          stop,
   input  txdma_mode_e   mode,
   input  logic          circ,
   input  logic [AW-1:0] start,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   input  logic [CW-1:0] count,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [7:0]    mem_rdata,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   input  logic          tx_ready,
   output logic          busy,
   output logic [AW-1:0] ptr,
   output logic          irq_set,
   output logic          stop_pend
);

   localparam logic [CW-1:0] CNT_ONE = CW'(1);

   txdma_state_e  state_q;
   txdma_mode_e   run_mode_q;
   logic [AW-1:0] ptr_q, ptr_nxt;
   logic [CW-1:0] cnt_q, hdr_cnt;
   logic [7:0]    hdr_lo_q, data_q;
   logic          stop_q;
   logic          accept, last, hdr_zero, go_ok;

   txdma_addr #(.AW(AW), .WRAP_EN(WRAP_EN)) u_addr (
      .cur  (ptr_q),
      .lo   (lo),
      .hi   (hi),
      .circ (circ),
      .nxt  (ptr_nxt)
   );

   always_comb begin
      accept   = (state_q == ST_DAT_OUT) && tx_ready;
      last     = (cnt_q == CNT_ONE);
      hdr_cnt  = CW'({mem_rdata, hdr_lo_q});
      hdr_zero = (hdr_cnt == '0);
      go_ok    = go && ((mode == MODE_CHAIN) ||
                        (((mode == MODE_ONESHOT) || (mode == MODE_FREERUN)) && (count != '0)));
      irq_set  = ((state_q == ST_HHI_WAIT) && mem_rvalid && hdr_zero) ||
                 (accept && last && (run_mode_q != MODE_CHAIN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         run_mode_q <= MODE_CHAIN;
         ptr_q      <= '0;
         cnt_q      <= '0;
         hdr_lo_q   <= '0;
         data_q     <= '0;
         stop_q     <= 1'b0;
      end else begin
         if (stop && (state_q != ST_IDLE)) stop_q <= 1'b1;
         case (state_q)
            ST_IDLE: begin
               stop_q <= 1'b0;
               if (go_ok) begin
                  ptr_q      <= start;
                  run_mode_q <= mode;
                  cnt_q      <= count;
                  state_q    <= (mode == MODE_CHAIN) ? ST_HLO_REQ : ST_DAT_REQ;
               end
            end
            ST_HLO_REQ: state_q <= ST_HLO_WAIT;
            ST_HLO_WAIT: begin
               if (mem_rvalid) begin
                  hdr_lo_q <= mem_rdata;
                  ptr_q    <= ptr_nxt;
                  state_q  <= ST_HHI_REQ;
               end
            end
            ST_HHI_REQ: state_q <= ST_HHI_WAIT;
            ST_HHI_WAIT: begin
               if (mem_rvalid) begin
                  ptr_q   <= ptr_nxt;
                  cnt_q   <= hdr_cnt;
                  state_q <= hdr_zero ? ST_IDLE : ST_DAT_REQ;
               end
            end
            ST_DAT_REQ: state_q <= ST_DAT_WAIT;
            ST_DAT_WAIT: begin
               if (mem_rvalid) begin
                  data_q  <= mem_rdata;
                  state_q <= ST_DAT_OUT;
               end
            end
            ST_DAT_OUT: begin
               if (tx_ready) begin
                  ptr_q <= ptr_nxt;
                  if (stop_q || stop) begin
                     state_q <= ST_IDLE;
                  end else if (last) begin
                     case (run_mode_q)
                        MODE_CHAIN:   state_q <= ST_HLO_REQ;
                        MODE_FREERUN: begin
                           cnt_q   <= count;
                           state_q <= ST_DAT_REQ;
                        end
                        default:      state_q <= ST_IDLE;
                     endcase
                  end else begin
                     cnt_q   <= cnt_q - CNT_ONE;
                     state_q <= ST_DAT_REQ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q == ST_HLO_REQ) || (state_q == ST_HHI_REQ) || (state_q == ST_DAT_REQ);
   assign mem_addr  = ptr_q;
   assign tx_valid  = (state_q == ST_DAT_OUT);
   assign tx_data   = data_q;
   assign busy      = (state_q != ST_IDLE);
   assign ptr       = ptr_q;
   assign stop_pend = stop_q;

endmodule

// File: rtl/txdma_chan.sv
module txdma_chan
   import txdma_pkg::*;
#(
   parameter int AW      = 16,
   parameter int CW      = 16,
   parameter int DW      = 16,
   parameter bit WRAP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [DW-1:0] cfg_wdata,
   output logic [DW-1:0] cfg_rdata,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_rvalid,
   input  logic [7:0]    mem_rdata,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   input  logic          tx_ready,
   output logic          irq
);

   generate
      if (CW < HDR_BITS) begin : g_bad_cw
         $error("txdma_chan: CW must hold a 16-bit header length");
      end
      if ((DW < AW) || (DW < CW) || (DW < 4)) begin : g_bad_dw
         $error("txdma_chan: DW must cover AW, CW and the control field");
      end
   endgenerate

   txdma_mode_e   mode_w;
   logic          circ_w, mask_w, go_w, stop_w, status_w, busy_w, irq_set_w, stop_pend_w;
   logic [AW-1:0] start_w, lo_w, hi_w, ptr_w;
   logic [CW-1:0] count_w;

   txdma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .busy      (busy_w),
      .ptr       (ptr_w),
      .irq_set   (irq_set_w),
      .mode      (mode_w),
      .circ      (circ_w),
      .mask      (mask_w),
      .start     (start_w),
      .lo        (lo_w),
      .hi        (hi_w),
      .count     (count_w),
      .go        (go_w),
      .stop      (stop_w),
      .status    (status_w),
      .irq       (irq)
   );

   txdma_engine #(.AW(AW), .CW(CW), .WRAP_EN(WRAP_EN)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go_w),
      .stop       (stop_w),
      .mode       (mode_w),
      .circ       (circ_w),
      .start      (start_w),
      .lo         (lo_w),
      .hi         (hi_w),
      .count      (count_w),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_ready   (tx_ready),
      .busy       (busy_w),
      .ptr        (ptr_w),
      .irq_set    (irq_set_w),
      .stop_pend  (stop_pend_w)
   );

endmodule

// File: rtl/txdma_chan_chk.sv
module txdma_chan_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       mem_req,
   input logic       mem_rvalid,
   input logic       irq,
   input logic       irq_mask,
   input logic       irq_status,
   input logic       status_clr,
   input logic       stop_pend,
   input logic       busy
);

   logic outstanding_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          outstanding_q <= 1'b0;
      else if (mem_req)    outstanding_q <= 1'b1;
      else if (mem_rvalid) outstanding_q <= 1'b0;
   end

   assert_no_req_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |-> !mem_req);

   assert_hold_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

   assert_req_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !outstanding_q);

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_mask && irq_status));

   assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_status && !status_clr) |=> irq_status);

   assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pend && tx_valid && tx_ready) |=> !busy);

endmodule

bind txdma_chan txdma_chan_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_data    (tx_data),
   .mem_req    (mem_req),
   .mem_rvalid (mem_rvalid),
   .irq        (irq),
   .irq_mask   (mask_w),
   .irq_status (status_w),
   .status_clr (cfg_we && (cfg_addr == 3'd6) && cfg_wdata[0]),
   .stop_pend  (stop_pend_w),
   .busy       (busy_w)
);

// File: tb/txdma_chan_tb.sv
`timescale 1ns/1ps
module txdma_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = 3'd6;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int n = 0;
   int rdy_sel = 0;
   int stall_req = 0;
   int req_viol = 0;
   logic        pend = 1'b0;
   logic [15:0] pend_addr = '0;
   logic [7:0]  mem [0:255];
   logic [7:0]  got [0:511];

   always #4 clk = ~clk;

   txdma_chan u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .tx_valid   (tx_valid),
      .tx_data    (tx_data),
      .tx_ready   (tx_ready),
      .irq        (irq)
   );

   // UART sink and memory model, both driven away from the rising edge
   always @(negedge clk) begin
      cyc++;
      case (rdy_sel)
         0:       tx_ready = 1'b1;
         1:       tx_ready = (cyc % 2) == 0;
         default: tx_ready = 1'b0;
      endcase
      if (tx_valid && tx_ready && n < 512) begin
         got[n] = tx_data;
         n++;
      end
      if (mem_req && tx_valid && !tx_ready) stall_req++;
      mem_rvalid = 1'b0;
      if (mem_req && pend) req_viol++;
      if (pend) begin
         mem_rvalid = 1'b1;
         mem_rdata  = mem[pend_addr[7:0]];
         pend = 1'b0;
      end
      if (mem_req) begin
         pend = 1'b1;
         pend_addr = mem_addr;
      end
   end

   always @(negedge clk) begin
      if (cyc == 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [15:0] nxt(input logic [15:0] a, input bit circ,
                                       input logic [15:0] lo, input logic [15:0] hi);
      return (circ && a == hi) ? lo : a + 16'd1;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = 3'd6;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
      cfg_addr = 3'd6;
   endtask

   task automatic wait_idle(input string tag);
      bit still = 1'b1;
      cfg_addr = 3'd6;
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         #1;
         if (!cfg_rdata[1]) begin still = 1'b0; break; end
      end
      chk(!still, tag, still, 0);
   endtask

   task automatic seq(input int base, input int cnt, input logic [15:0] st, input bit circ,
                      input logic [15:0] lo, input logic [15:0] hi,
                      output int bad, output logic [15:0] ep);
      logic [15:0] a = st;
      bad = 0;
      for (int i = 0; i < cnt; i++) begin
         if (got[base + i] !== mem[a[7:0]]) bad++;
         a = nxt(a, circ, lo, hi);
      end
      ep = a;
   endtask

   // {ctrl, start, lo, hi, count}; ctrl = mode | circ<<2 | mask<<3
   localparam logic [79:0] VEC [0:3] = '{
      {16'h0009, 16'h0010, 16'h0018, 16'h001F, 16'd5},
      {16'h000D, 16'h001E, 16'h0018, 16'h001F, 16'd6},
      {16'h000D, 16'h001F, 16'h0018, 16'h001F, 16'd1},
      {16'h0009, 16'h001E, 16'h0018, 16'h001F, 16'd4}
   };

   initial begin
      logic [15:0] d, ep;
      int bad, base;
      logic [7:0] held;

      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 5 + 1);

      repeat (3) @(negedge clk);
      #1;
      chk(!tx_valid && !mem_req && !irq, "R1 outputs after reset", {tx_valid, mem_req, irq}, 0);
      chk(cfg_rdata == 16'h0, "R1 status after reset", cfg_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!tx_valid && !mem_req && !irq, "R1 outputs idle post reset", {tx_valid, mem_req, irq}, 0);

      // one-shot table walk
      for (int row = 0; row < 4; row++) begin
         logic [15:0] c, st, lo, hi, cn;
         {c, st, lo, hi, cn} = VEC[row];
         rdy_sel = row % 2;
         wr(3'd0, c); wr(3'd1, st); wr(3'd2, lo); wr(3'd3, hi); wr(3'd4, cn);
         base = n;
         wr(3'd5, 16'h1);
         wait_idle("R2 one-shot finishes");
         chk(n - base == int'(cn), "R2 byte count", n - base, cn);
         seq(base, int'(cn), st, c[2], lo, hi, bad, ep);
         chk(bad == 0, c[2] ? "R8 circular byte order" : "R9 linear byte order", bad, 0);
         rd(3'd7, d);
         chk(d == ep, c[2] ? "R8 pointer after wrap" : "R9 pointer past hi", d, ep);
         chk(irq == 1'b1, "R10 irq set on completion", irq, 1);
         wr(3'd6, 16'h1);
         #1;
         chk(irq == 1'b0 && cfg_rdata[0] == 1'b0, "R10 write-one clears flag", cfg_rdata, 0);
      end
      rdy_sel = 0;

      // zero count and reserved mode are ignored
      base = n;
      wr(3'd0, 16'h0009); wr(3'd4, 16'd0); wr(3'd5, 16'h1);
      repeat (10) @(negedge clk);
      #1;
      chk(cfg_rdata == 16'h0 && n == base, "R3 zero count one-shot ignored", cfg_rdata, 0);
      wr(3'd0, 16'h000A); wr(3'd5, 16'h1);
      repeat (10) @(negedge clk);
      #1;
      chk(cfg_rdata == 16'h0 && n == base, "R3 zero count free-run ignored", cfg_rdata, 0);
      wr(3'd0, 16'h000B); wr(3'd4, 16'd3); wr(3'd5, 16'h1);
      repeat (10) @(negedge clk);
      #1;
      chk(cfg_rdata == 16'h0 && n == base, "R3 reserved mode ignored", cfg_rdata, 0);

      // header chaining: 3 bytes, 2 bytes, then end of chain
      mem[8'h40] = 8'h03; mem[8'h41] = 8'h00;
      mem[8'h45] = 8'h02; mem[8'h46] = 8'h00;
      mem[8'h49] = 8'h00; mem[8'h4A] = 8'h00;
      wr(3'd0, 16'h0008); wr(3'd1, 16'h0040);
      base = n;
      wr(3'd5, 16'h1);
      wait_idle("R4 chain finishes");
      chk(n - base == 5, "R4 chained byte total", n - base, 5);
      bad = 0;
      if (got[base]   !== mem[8'h42]) bad++;
      if (got[base+1] !== mem[8'h43]) bad++;
      if (got[base+2] !== mem[8'h44]) bad++;
      if (got[base+3] !== mem[8'h47]) bad++;
      if (got[base+4] !== mem[8'h48]) bad++;
      chk(bad == 0, "R4 chained data skips headers", bad, 0);
      rd(3'd7, d);
      chk(d == 16'h004B, "R5 pointer after zero header", d, 16'h004B);
      chk(irq == 1'b1, "R5 zero header raises irq", irq, 1);
      wr(3'd6, 16'h1);

      // mask disabled: flag set, pin quiet
      wr(3'd0, 16'h0001); wr(3'd1, 16'h0030); wr(3'd4, 16'd2); wr(3'd5, 16'h1);
      wait_idle("R10 masked run finishes");
      chk(irq == 1'b0 && cfg_rdata[0] == 1'b1, "R10 mask gates irq", {irq, cfg_rdata[0]}, 2'b01);
      wr(3'd6, 16'h1);

      // free-running with rollover every 3 bytes, circular window 0x60..0x63
      wr(3'd0, 16'h000E); wr(3'd1, 16'h0060); wr(3'd2, 16'h0060); wr(3'd3, 16'h0063);
      wr(3'd4, 16'd3);
      base = n;
      wr(3'd5, 16'h1);
      wait (n - base == 2);
      chk(irq == 1'b0, "R6 no irq before rollover", irq, 0);
      wait (n - base == 3);
      @(negedge clk);
      chk(irq == 1'b1, "R6 irq on first rollover", irq, 1);
      wr(3'd6, 16'h1);
      wait (n - base == 5);
      chk(irq == 1'b0, "R6 flag cleared mid run", irq, 0);
      wait (n - base == 6);
      @(negedge clk);
      chk(irq == 1'b1, "R6 irq on reload rollover", irq, 1);
      wr(3'd5, 16'h2);
      wait_idle("R7 stop reaches idle");
      seq(base, n - base, 16'h0060, 1'b1, 16'h0060, 16'h0063, bad, ep);
      chk(bad == 0 && (n - base) >= 7, "R7 bytes before stop", n - base, 7);
      rd(3'd7, d);
      chk(d == ep, "R7 pointer preserved at stop", d, ep);
      base = n;
      repeat (20) @(negedge clk);
      chk(n == base && !tx_valid, "R7 nothing sent after stop", n - base, 0);
      wr(3'd6, 16'h1);

      // back-pressure from the UART
      rdy_sel = 2;
      wr(3'd0, 16'h0009); wr(3'd1, 16'h0070); wr(3'd4, 16'd3);
      base = n;
      stall_req = 0;
      wr(3'd5, 16'h1);
      repeat (20) @(negedge clk);
      chk(tx_valid && tx_data == mem[8'h70], "R11 first byte presented", tx_data, mem[8'h70]);
      held = tx_data;
      repeat (5) @(negedge clk);
      chk(tx_data == held && stall_req == 0, "R11 stall holds data, no reads", stall_req, 0);
      rdy_sel = 0;
      wait_idle("R11 stalled run finishes");
      seq(base, 3, 16'h0070, 1'b0, 16'h0, 16'h0, bad, ep);
      chk(n - base == 3 && bad == 0, "R11 bytes after release", bad, 0);

      chk(req_viol == 0, "R12 one request outstanding", req_viol, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule